// File: doc/BRIEF.md
# Power Island Sequencer with Stepped Inrush Limit

This block brings one switchable power island up and down in hardware. A one-cycle power-up request starts a bring-up sequence. The sequencer closes the island's power switches at the lowest inrush-current setting. It waits a bounded number of cycles for the island to report power-good. If that time runs out, it raises the setting by one step and waits again, for up to four settings in all. Once power is good it releases electrical isolation, starts memory repair, waits for repair completion and then releases functional isolation.

A one-cycle power-down request applies the isolations and opens the switches, in the reverse order of bring-up. When bring-up fails, only the steps already taken are undone. Each finished sequence raises exactly one of three one-cycle status pulses: done, power-good timeout or repair timeout. Both timeout lengths are parameters counted in clock cycles.

Top module: `pwr_island_seq`

## Requirements
- R1: After reset, sw_en_o=0, inrush_o=0, elec_iso_o=1, func_iso_o=1, repair_start_o=0, and no status pulse is raised.
- R2: A power-up request in idle while sw_en_o is already 1 changes no island output and raises done_o in the next cycle.
- R3: Bring-up sets sw_en_o=1 with inrush_o=0. While power-good stays low, each code is held for PG_TMO cycles and then replaced by the next code, in the order 0, 1, 2, 3. Code 0 selects about 3.5 mA, code 1 about 5 mA, code 2 about 10 mA and code 3 about 20 mA.
- R4: If code 3 also times out, sw_en_o and inrush_o go to 0 in the same cycle that pg_tmo_o pulses, and both isolations stay applied.
- R5: When power-good is seen, inrush_o keeps the code that succeeded. elec_iso_o falls first, and repair_start_o rises exactly one cycle later.
- R6: When repair-done arrives within REP_TMO cycles of repair_start_o rising, then in a single cycle func_iso_o falls, repair_start_o falls and done_o pulses. A repair-done seen on the REP_TMO-th cycle still counts as success.
- R7: If repair-done is still missing after REP_TMO cycles, then in a single cycle elec_iso_o returns to 1, sw_en_o, inrush_o and repair_start_o go to 0, and rep_tmo_o pulses. func_iso_o stays 1.
- R8: Power-down takes three cycles. In the first cycle func_iso_o rises. In the second cycle elec_iso_o rises. In the third cycle sw_en_o and inrush_o go to 0 and done_o pulses.
- R9: Power-up and power-down requests that arrive while a sequence is running are ignored.
- R10: If both requests arrive together in idle, the power-up request wins.
- R11: done_o, pg_tmo_o and rep_tmo_o each last one cycle, and at most one of them is high in any cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset, released synchronously inside |
| up_req_i | input | 1 | Power-up request, one cycle |
| down_req_i | input | 1 | Power-down request, one cycle |
| pgood_i | input | 1 | Power-good from the island |
| repair_done_i | input | 1 | Memory repair complete |
| sw_en_o | output | 1 | Power switches closed |
| inrush_o | output | 2 | Inrush limit code (0 lowest, 3 highest) |
| elec_iso_o | output | 1 | Electrical isolation applied |
| func_iso_o | output | 1 | Functional isolation applied |
| repair_start_o | output | 1 | Memory repair request |
| done_o | output | 1 | Sequence finished successfully (pulse) |
| pg_tmo_o | output | 1 | Power-good timeout (pulse) |
| rep_tmo_o | output | 1 | Repair timeout (pulse) |

## Verification
The hardest case to reach is a power-good that arrives only at a chosen inrush step, together with a repair-done that lands exactly on the last allowed cycle or one cycle after it. The bench models the island from the sequencer's own outputs. It raises power-good only once inrush_o has reached a threshold taken from a vector table. It counts the cycles for which repair_start_o has been high and raises repair-done at a chosen count. This lets each table row pick the inrush step that succeeds and place the repair edge on either side of the timeout. Stray requests are injected in the middle of each sequence.

// File: rtl/pwr_seq_pkg.sv
`timescale 1ns/1ps
package pwr_seq_pkg;
  localparam int INRUSH_W = 2;
  localparam logic [INRUSH_W-1:0] INRUSH_LOW  = '0;
  localparam logic [INRUSH_W-1:0] INRUSH_HIGH = '1;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_RAMP,
    ST_PREP,
    ST_REPAIR,
    ST_DN_ELEC,
    ST_DN_OPEN
  } seq_state_e;
endpackage

// File: rtl/pwr_seq_timer.sv
`timescale 1ns/1ps
module pwr_seq_timer #(
  parameter int CNT_W = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             clr_i,
  input  logic             en_i,
  input  logic [CNT_W-1:0] limit_i,
  output logic             expire_o
);
  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             cnt_we;

  always_comb begin
    cnt_we = clr_i | en_i;
    cnt_d  = clr_i ? '0 : cnt_q + {{(CNT_W-1){1'b0}}, 1'b1};
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     cnt_q <= '0;
    else if (cnt_we) cnt_q <= cnt_d;
  end

  assign expire_o = en_i && (cnt_q == limit_i - {{(CNT_W-1){1'b0}}, 1'b1});
endmodule

// File: rtl/pwr_seq_ctrl.sv
`timescale 1ns/1ps
module pwr_seq_ctrl
  import pwr_seq_pkg::*;
(
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                up_req_i,
  input  logic                down_req_i,
  input  logic                pgood_i,
  input  logic                repair_done_i,
  input  logic                tmr_expire_i,
  output logic                tmr_clr_o,
  output logic                tmr_en_o,
  output logic                tmr_rep_sel_o,
  output logic                sw_en_o,
  output logic [INRUSH_W-1:0] inrush_o,
  output logic                elec_iso_o,
  output logic                func_iso_o,
  output logic                repair_start_o,
  output logic                done_o,
  output logic                pg_tmo_o,
  output logic                rep_tmo_o
);
  seq_state_e          st_q, st_d;
  logic                sw_q, sw_d, eiso_q, eiso_d, fiso_q, fiso_d, rs_q, rs_d;
  logic [INRUSH_W-1:0] inr_q, inr_d;
  logic                done_q, done_d, pgt_q, pgt_d, rpt_q, rpt_d;

  always_comb begin
    st_d   = st_q;
    sw_d   = sw_q;
    inr_d  = inr_q;
    eiso_d = eiso_q;
    fiso_d = fiso_q;
    rs_d   = rs_q;
    done_d = 1'b0;
    pgt_d  = 1'b0;
    rpt_d  = 1'b0;
    tmr_clr_o     = 1'b0;
    tmr_en_o      = 1'b0;
    tmr_rep_sel_o = (st_q == ST_REPAIR);
    unique case (st_q)
      ST_IDLE: begin
        if (up_req_i) begin
          if (sw_q) begin
            done_d = 1'b1;
          end else begin
            sw_d      = 1'b1;
            inr_d     = INRUSH_LOW;
            tmr_clr_o = 1'b1;
            st_d      = ST_RAMP;
          end
        end else if (down_req_i) begin
          fiso_d = 1'b1;
          st_d   = ST_DN_ELEC;
        end
      end
      ST_RAMP: begin
        tmr_en_o = 1'b1;
        if (pgood_i) begin
          eiso_d = 1'b0;
          st_d   = ST_PREP;
        end else if (tmr_expire_i) begin
          if (inr_q == INRUSH_HIGH) begin
            sw_d  = 1'b0;
            inr_d = INRUSH_LOW;
            pgt_d = 1'b1;
            st_d  = ST_IDLE;
          end else begin
            inr_d     = inr_q + {{(INRUSH_W-1){1'b0}}, 1'b1};
            tmr_clr_o = 1'b1;
          end
        end
      end
      ST_PREP: begin
        rs_d      = 1'b1;
        tmr_clr_o = 1'b1;
        st_d      = ST_REPAIR;
      end
      ST_REPAIR: begin
        tmr_en_o = 1'b1;
        if (repair_done_i) begin
          fiso_d = 1'b0;
          rs_d   = 1'b0;
          done_d = 1'b1;
          st_d   = ST_IDLE;
        end else if (tmr_expire_i) begin
          eiso_d = 1'b1;
          sw_d   = 1'b0;
          inr_d  = INRUSH_LOW;
          rs_d   = 1'b0;
          rpt_d  = 1'b1;
          st_d   = ST_IDLE;
        end
      end
      ST_DN_ELEC: begin
        eiso_d = 1'b1;
        st_d   = ST_DN_OPEN;
      end
      ST_DN_OPEN: begin
        sw_d   = 1'b0;
        inr_d  = INRUSH_LOW;
        rs_d   = 1'b0;
        done_d = 1'b1;
        st_d   = ST_IDLE;
      end
      default: st_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q   <= ST_IDLE;
      sw_q   <= 1'b0;
      inr_q  <= INRUSH_LOW;
      eiso_q <= 1'b1;
      fiso_q <= 1'b1;
      rs_q   <= 1'b0;
      done_q <= 1'b0;
      pgt_q  <= 1'b0;
      rpt_q  <= 1'b0;
    end else begin
      st_q   <= st_d;
      sw_q   <= sw_d;
      inr_q  <= inr_d;
      eiso_q <= eiso_d;
      fiso_q <= fiso_d;
      rs_q   <= rs_d;
      done_q <= done_d;
      pgt_q  <= pgt_d;
      rpt_q  <= rpt_d;
    end
  end

  assign sw_en_o        = sw_q;
  assign inrush_o       = inr_q;
  assign elec_iso_o     = eiso_q;
  assign func_iso_o     = fiso_q;
  assign repair_start_o = rs_q;
  assign done_o         = done_q;
  assign pg_tmo_o       = pgt_q;
  assign rep_tmo_o      = rpt_q;
endmodule

// File: rtl/pwr_island_seq.sv
`timescale 1ns/1ps
module pwr_island_seq
  import pwr_seq_pkg::*;
#(
  parameter int PG_TMO  = 150,
  parameter int REP_TMO = 50
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                up_req_i,
  input  logic                down_req_i,
  input  logic                pgood_i,
  input  logic                repair_done_i,
  output logic                sw_en_o,
  output logic [INRUSH_W-1:0] inrush_o,
  output logic                elec_iso_o,
  output logic                func_iso_o,
  output logic                repair_start_o,
  output logic                done_o,
  output logic                pg_tmo_o,
  output logic                rep_tmo_o
);
  localparam int MAX_TMO = (PG_TMO > REP_TMO) ? PG_TMO : REP_TMO;
  localparam int CNT_W   = $clog2(MAX_TMO + 1);
  localparam logic [CNT_W-1:0] PG_LIM  = CNT_W'(PG_TMO);
  localparam logic [CNT_W-1:0] REP_LIM = CNT_W'(REP_TMO);

  logic [1:0]       rst_sync_q;
  logic             rst_n_int;
  logic             tmr_clr, tmr_en, tmr_rep_sel, tmr_expire;
  logic [CNT_W-1:0] tmr_limit;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) rst_sync_q <= 2'b00;
    else         rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_n_int = rst_sync_q[1];

  assign tmr_limit = tmr_rep_sel ? REP_LIM : PG_LIM;

  pwr_seq_timer #(.CNT_W(CNT_W)) u_timer (
    .clk_i    (clk_i),
    .rst_ni   (rst_n_int),
    .clr_i    (tmr_clr),
    .en_i     (tmr_en),
    .limit_i  (tmr_limit),
    .expire_o (tmr_expire)
  );

  pwr_seq_ctrl u_ctrl (
    .clk_i          (clk_i),
    .rst_ni         (rst_n_int),
    .up_req_i       (up_req_i),
    .down_req_i     (down_req_i),
    .pgood_i        (pgood_i),
    .repair_done_i  (repair_done_i),
    .tmr_expire_i   (tmr_expire),
    .tmr_clr_o      (tmr_clr),
    .tmr_en_o       (tmr_en),
    .tmr_rep_sel_o  (tmr_rep_sel),
    .sw_en_o        (sw_en_o),
    .inrush_o       (inrush_o),
    .elec_iso_o     (elec_iso_o),
    .func_iso_o     (func_iso_o),
    .repair_start_o (repair_start_o),
    .done_o         (done_o),
    .pg_tmo_o       (pg_tmo_o),
    .rep_tmo_o      (rep_tmo_o)
  );
endmodule

// File: rtl/pwr_island_seq_chk.sv
`timescale 1ns/1ps
module pwr_island_seq_chk (
  input logic       clk_i,
  input logic       rst_ni,
  input logic       sw_en_o,
  input logic [1:0] inrush_o,
  input logic       elec_iso_o,
  input logic       func_iso_o,
  input logic       repair_start_o,
  input logic       done_o,
  input logic       pg_tmo_o,
  input logic       rep_tmo_o
);
  // R3
  inrush_step_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sw_en_o && $past(sw_en_o) && (inrush_o != $past(inrush_o)))
      |-> (inrush_o == $past(inrush_o) + 2'd1));
  // R3
  ramp_start_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(sw_en_o) |-> (inrush_o == 2'd0));
  // R4
  off_inrush_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !sw_en_o |-> (inrush_o == 2'd0));
  // R5
  repair_iso_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(repair_start_o) |-> (!elec_iso_o && sw_en_o));
  // R6
  func_release_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(func_iso_o) |-> (!elec_iso_o && sw_en_o && done_o));
  // R8
  elec_apply_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(elec_iso_o) |-> func_iso_o);
  // R8
  sw_open_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(sw_en_o) |-> (elec_iso_o && func_iso_o));
  // R11
  pulse_excl_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0({done_o, pg_tmo_o, rep_tmo_o}));
  // R11
  done_len_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o);
endmodule

bind pwr_island_seq pwr_island_seq_chk u_chk (
  .clk_i          (clk_i),
  .rst_ni         (rst_ni),
  .sw_en_o        (sw_en_o),
  .inrush_o       (inrush_o),
  .elec_iso_o     (elec_iso_o),
  .func_iso_o     (func_iso_o),
  .repair_start_o (repair_start_o),
  .done_o         (done_o),
  .pg_tmo_o       (pg_tmo_o),
  .rep_tmo_o      (rep_tmo_o)
);

// File: tb/pwr_island_seq_test.sv
`timescale 1ns/1ps
module pwr_island_seq_test;
  localparam int PG_T  = 150;
  localparam int REP_T = 50;
  localparam int NV    = 6;
  // power-good threshold code (4 = never) and repair-done delay in cycles
  localparam int VEC_THR [NV] = '{0, 2, 3, 1, 4, 1};
  localparam int VEC_DLY [NV] = '{3, 10, REP_T, REP_T + 1, 3, REP_T - 1};
  localparam int RES_DONE = 1, RES_PG = 2, RES_REP = 3, RES_NONE = 0;

  logic clk = 1'b0, rst_n = 1'b0;
  logic up_req = 1'b0, down_req = 1'b0, pgood = 1'b0, rep_done = 1'b0;
  logic sw_en, elec_iso, func_iso, repair_start, done, pg_tmo, rep_tmo;
  logic [1:0] inrush;
  int checks = 0, failures = 0;
  int code_cnt [4];
  int ef_cyc, rr_cyc;

  always #10 clk = ~clk;

  pwr_island_seq #(.PG_TMO(PG_T), .REP_TMO(REP_T)) uut (
    .clk_i(clk), .rst_ni(rst_n), .up_req_i(up_req), .down_req_i(down_req),
    .pgood_i(pgood), .repair_done_i(rep_done), .sw_en_o(sw_en),
    .inrush_o(inrush), .elec_iso_o(elec_iso), .func_iso_o(func_iso),
    .repair_start_o(repair_start), .done_o(done), .pg_tmo_o(pg_tmo),
    .rep_tmo_o(rep_tmo)
  );

  task automatic chk(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic do_reset();
    rst_n = 1'b0; up_req = 0; down_req = 0; pgood = 0; rep_done = 0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
  endtask

  task automatic run_up(input int thr, input int dly, output int res);
    int rcnt = 0;
    res = RES_NONE;
    for (int k = 0; k < 4; k++) code_cnt[k] = 0;
    ef_cyc = -1; rr_cyc = -1;
    up_req = 1'b1;
    @(negedge clk);
    up_req = 1'b0;
    for (int it = 0; it < 3000; it++) begin
      if (done) begin res = RES_DONE; break; end
      if (pg_tmo) begin res = RES_PG; break; end
      if (rep_tmo) begin res = RES_REP; break; end
      if (sw_en && !repair_start && elec_iso) code_cnt[inrush]++;
      if (!elec_iso && ef_cyc < 0) ef_cyc = it;
      if (repair_start && rr_cyc < 0) rr_cyc = it;
      down_req = (it == 3);              // R9 stray request mid-sequence
      pgood = sw_en && (thr < 4) && (int'(inrush) >= thr);
      if (repair_start) rcnt++;
      rep_done = repair_start && (rcnt >= dly);
      @(negedge clk);
    end
    down_req = 1'b0; rep_done = 1'b0;
  endtask

  initial begin
    #(20 * 190000);
    failures++;
    $display("FAIL watchdog actual=1 expected=0");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    int res, exp_res;
    do_reset();
    // R1 reset state
    chk("R1 sw_en", sw_en, 0);
    chk("R1 inrush", inrush, 0);
    chk("R1 elec_iso", elec_iso, 1);
    chk("R1 func_iso", func_iso, 1);
    chk("R1 repair_start", repair_start, 0);
    chk("R1 pulses", {done, pg_tmo, rep_tmo}, 0);

    for (int v = 0; v < NV; v++) begin
      exp_res = (VEC_THR[v] > 3) ? RES_PG : (VEC_DLY[v] > REP_T) ? RES_REP : RES_DONE;
      run_up(VEC_THR[v], VEC_DLY[v], res);
      chk("R9/R6 result", res, exp_res);
      for (int k = 0; k < 4; k++)
        if (k < VEC_THR[v]) chk("R3 code dwell", code_cnt[k], PG_T);
      if (exp_res == RES_PG) begin
        chk("R4 sw_en", sw_en, 0);
        chk("R4 inrush", inrush, 0);
        chk("R4 iso", {elec_iso, func_iso}, 3);
      end else begin
        chk("R5 repair one cycle after elec release", rr_cyc - ef_cyc, 1);
      end
      if (exp_res == RES_REP) begin
        chk("R7 sw_en", sw_en, 0);
        chk("R7 inrush", inrush, 0);
        chk("R7 iso", {elec_iso, func_iso}, 3);
        chk("R7 repair_start", repair_start, 0);
      end
      if (exp_res == RES_DONE) begin
        chk("R5 inrush kept", inrush, VEC_THR[v]);
        chk("R6 iso released", {elec_iso, func_iso}, 0);
        chk("R6 repair_start", repair_start, 0);
        chk("R6 sw_en", sw_en, 1);
        @(negedge clk);
        chk("R11 done one cycle", done, 0);
        // R2 already powered
        up_req = 1'b1; @(negedge clk); up_req = 1'b0;
        chk("R2 done", done, 1);
        chk("R2 outputs unchanged", {sw_en, elec_iso, func_iso, repair_start}, 4'b1000);
        @(negedge clk);
        // R8 power-down order, R9 up request mid-sequence
        down_req = 1'b1; @(negedge clk); down_req = 1'b0;
        chk("R8 step1", {func_iso, elec_iso, sw_en}, 3'b101);
        up_req = 1'b1; @(negedge clk); up_req = 1'b0;
        chk("R8 step2", {func_iso, elec_iso, sw_en, done}, 4'b1110);
        @(negedge clk);
        chk("R8 step3", {sw_en, inrush, done}, 4'b0001);
        pgood = 1'b0;
        @(negedge clk);
        chk("R9 up ignored", {sw_en, done}, 0);
      end
      @(negedge clk);
    end

    // R10 simultaneous requests
    up_req = 1'b1; down_req = 1'b1; @(negedge clk); up_req = 0; down_req = 0;
    chk("R10 up wins", {sw_en, func_iso, elec_iso}, 3'b111);
    @(negedge clk);
    do_reset();
    chk("R1 after reset", {sw_en, elec_iso, func_iso, repair_start}, 4'b0110);

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule